// File: doc/BRIEF.md
# Slot Power Sequencer with Trip Policy

This block runs the power rail of a single chassis slot. It raises the slot enable only after the backplane reports that its supply is stable. It then waits for the plugged-in module to report power-good, and only after that does it declare the slot operational. While the rail is up it watches four comparator flags: undervoltage, overvoltage, overcurrent and overtemperature. It also watches the power-good line itself and the backplane supply. When a protection trip occurs, the rail is dropped and a software-selected policy decides what happens next. The three policies are a plain shutdown, a timed retry, and a latch-off that only an explicit clear can release.

Four 8-bit saturating health counters keep a record of the slot's faults. Every enable, disable, trip, retry and latch-off produces one event record per cycle. The record carries a flag set, a reason code and the value of a free-running timestamp. Downstream logic uses `slot_ready` to gate synchronized operation across slots and `alarm` to raise an operator alarm.

The state machine has six states:
- S_IDLE: rail off, waiting for the backplane.
- S_RAMP: rail on, waiting for power-good.
- S_ON: operational.
- S_BACKOFF: retry off-time.
- S_HALT: shutdown, waiting for the faults to clear.
- S_LATCH: latched off.

The transitions are named as follows:
- power-up: S_IDLE→S_RAMP.
- good: S_RAMP→S_ON.
- trip: S_RAMP or S_ON to S_HALT, S_BACKOFF or S_LATCH, chosen by the policy.
- brownout: S_RAMP or S_ON to S_IDLE.
- re-arm: S_BACKOFF→S_RAMP.
- release: S_HALT→S_IDLE.
- clear: S_LATCH→S_IDLE.

Top module: `slot_pwr_seq`

## Requirements
- R1: `slot_en` rises on the clock edge after `bp_stable` is sampled high in S_IDLE. `slot_ready` rises only on the edge after `mod_pg` is sampled high while `slot_en` is already high.
- R2: The ramp timer restarts at the edge that raises `slot_en`. If `mod_pg` is still low `pg_timeout`+1 edges later, the slot trips with reason 5 (inrush) and `cnt_inrush` increments.
- R3: In S_RAMP or S_ON, any comparator flag trips the slot on the next edge. The reason code is 3 for overcurrent, 2 for overvoltage, 1 for undervoltage and 4 for overtemperature. When several flags are high at once, the priority is overcurrent over overvoltage over undervoltage over overtemperature. Loss of `mod_pg` in S_ON trips with reason 1. `cnt_oc` and `cnt_uv` count trips whose reason is 3 or 1.
- R4: Policy 0 (shutdown) holds the rail off and `alarm` high while any flag stays high. When the flags clear, it returns to S_IDLE and sequences again.
- R5: Policy 1 (retry) holds the rail off for `backoff_len`+1 cycles. It then re-enables with the event flags ENABLE and RETRY together.
- R6: Under policy 1, a trip that occurs when `retry_limit` consecutive retries have already failed latches the slot off instead of retrying. The count of failed retries restarts whenever the slot reaches S_ON or S_IDLE.
- R7: Policies 2 and 3 latch off on the first trip. S_LATCH is left only by `clear_latch`; the same input has no effect in any other state.
- R8: If `bp_stable` falls while `slot_en` is high, the slot disables on the next edge with reason 6. This disable carries no TRIP flag and applies no policy: the slot goes back to S_IDLE with `alarm` low. `cnt_brownout` increments.
- R9: The four health counters reset to 0 and stop at 255 rather than wrapping.
- R10: An event record is valid for one cycle, together with the state change it describes. The flag bits are: bit0 ENABLE, bit1 DISABLE, bit2 TRIP, bit3 RETRY, bit4 LATCH. `evt_time` differs between two records by exactly the number of clock cycles between them.
- R11: `slot_ready` is high only in S_ON, and `sync_inhibit` is its inverse. `alarm` is high in S_HALT, S_BACKOFF and S_LATCH, and `slot_en` is low whenever `alarm` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_stable | input | 1 | Backplane supply stable |
| mod_pg | input | 1 | Module power-good |
| flt_uv | input | 1 | Undervoltage comparator |
| flt_ov | input | 1 | Overvoltage comparator |
| flt_oc | input | 1 | Overcurrent comparator |
| flt_ot | input | 1 | Overtemperature comparator |
| trip_policy | input | 2 | 0 shutdown, 1 retry, 2/3 latch-off |
| pg_timeout | input | TW | Power-good wait limit in cycles |
| backoff_len | input | TW | Retry off-time |
| retry_limit | input | RW | Failed retries allowed before latch-off |
| clear_latch | input | 1 | Releases S_LATCH |
| slot_en | output | 1 | Slot rail enable |
| slot_ready | output | 1 | Slot operational |
| sync_inhibit | output | 1 | Inhibit synchronized operation |
| alarm | output | 1 | Fault alarm |
| evt_valid | output | 1 | Event record valid |
| evt_flags | output | 5 | Event flag set |
| evt_reason | output | 3 | Event reason code |
| evt_time | output | TSW | Event timestamp |
| cnt_inrush | output | CW | Power-good timeout trips |
| cnt_oc | output | CW | Overcurrent trips |
| cnt_uv | output | CW | Undervoltage trips |
| cnt_brownout | output | CW | Backplane brownouts |

## Verification
The bench targets the corner cases below; each line names the case and the fault it exposes.
- Simultaneous flags: a reversed priority encoder would report undervoltage where overcurrent was asserted, and it would count the wrong counter.
- Ramp timeout: counting off by one would move the inrush trip by a cycle, which the timestamp difference exposes.
- Retry exhaustion: a design that compared against the limit wrongly would latch on the second or fourth trip instead of the third.
- `clear_latch` outside S_LATCH: a design that honoured it there would drop a running slot.
- Brownout: a design that routed it through the trip policy would raise the alarm or set the TRIP flag.
- Saturation: more than 255 trips would wrap a counter that does not saturate back to a small value.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RAMP    = 3'd1,
        S_ON      = 3'd2,
        S_BACKOFF = 3'd3,
        S_HALT    = 3'd4,
        S_LATCH   = 3'd5
    } seq_state_t;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_UV     = 3'd1,
        RSN_OV     = 3'd2,
        RSN_OC     = 3'd3,
        RSN_OT     = 3'd4,
        RSN_INRUSH = 3'd5,
        RSN_BROWN  = 3'd6
    } reason_t;

    localparam int EVW       = 5;
    localparam int EV_ENABLE = 0;
    localparam int EV_DIS    = 1;
    localparam int EV_TRIP   = 2;
    localparam int EV_RETRY  = 3;
    localparam int EV_LATCH  = 4;

    localparam int NCTR      = 4;
    localparam int C_INRUSH  = 0;
    localparam int C_OC      = 1;
    localparam int C_UV      = 2;
    localparam int C_BROWN   = 3;

endpackage

// File: rtl/slot_fault_prio.sv
module slot_fault_prio
    import slot_pwr_pkg::*;
(
    input  logic    uv,
    input  logic    ov,
    input  logic    oc,
    input  logic    ot,
    output logic    hit,
    output reason_t rsn
);
    always_comb begin
        hit = uv | ov | oc | ot;
        if (oc)      rsn = RSN_OC;
        else if (ov) rsn = RSN_OV;
        else if (uv) rsn = RSN_UV;
        else if (ot) rsn = RSN_OT;
        else         rsn = RSN_NONE;
    end
endmodule

// File: rtl/slot_sat_ctr.sv
module slot_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/slot_evt_log.sv
module slot_evt_log
    import slot_pwr_pkg::*;
#(
    parameter int TSW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_d,
    input  reason_t        rsn_d,
    output logic           evt_valid,
    output logic [EVW-1:0] evt_flags,
    output logic [2:0]     evt_reason,
    output logic [TSW-1:0] evt_time
);
    logic [TSW-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_flags  <= '0;
            evt_reason <= '0;
            evt_time   <= '0;
        end else begin
            evt_valid  <= |ev_d;
            evt_flags  <= ev_d;
            evt_reason <= rsn_d;
            if (|ev_d) evt_time <= ts_q;
        end
    end
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
    import slot_pwr_pkg::*;
#(
    parameter int TW  = 12,
    parameter int RW  = 4,
    parameter int CW  = 8,
    parameter int TSW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bp_stable,
    input  logic           mod_pg,
    input  logic           flt_uv,
    input  logic           flt_ov,
    input  logic           flt_oc,
    input  logic           flt_ot,
    input  logic [1:0]     trip_policy,
    input  logic [TW-1:0]  pg_timeout,
    input  logic [TW-1:0]  backoff_len,
    input  logic [RW-1:0]  retry_limit,
    input  logic           clear_latch,
    output logic           slot_en,
    output logic           slot_ready,
    output logic           sync_inhibit,
    output logic           alarm,
    output logic           evt_valid,
    output logic [4:0]     evt_flags,
    output logic [2:0]     evt_reason,
    output logic [TSW-1:0] evt_time,
    output logic [CW-1:0]  cnt_inrush,
    output logic [CW-1:0]  cnt_oc,
    output logic [CW-1:0]  cnt_uv,
    output logic [CW-1:0]  cnt_brownout
);
    localparam logic [TW-1:0] TMR_TOP = {TW{1'b1}};

    seq_state_t     st_q, st_d;
    logic [TW-1:0]  tmr_q;
    logic [RW-1:0]  rty_q;
    logic           tmr_clr, rty_inc, rty_clr, trip, brown;
    reason_t        trip_rsn, rsn_d, flt_rsn;
    logic           flt_hit;
    logic [EVW-1:0] ev_d;
    logic [NCTR-1:0] inc_vec;
    logic [CW-1:0]  cnt_arr [NCTR];

    slot_fault_prio prio_i (
        .uv(flt_uv), .ov(flt_ov), .oc(flt_oc), .ot(flt_ot),
        .hit(flt_hit), .rsn(flt_rsn)
    );

    always_comb begin
        st_d     = st_q;
        ev_d     = '0;
        rsn_d    = RSN_NONE;
        tmr_clr  = 1'b0;
        rty_inc  = 1'b0;
        rty_clr  = 1'b0;
        trip     = 1'b0;
        brown    = 1'b0;
        trip_rsn = RSN_NONE;
        unique case (st_q)
            S_IDLE: begin
                rty_clr = 1'b1;
                if (bp_stable) begin
                    st_d              = S_RAMP;
                    ev_d[EV_ENABLE]   = 1'b1;
                    tmr_clr           = 1'b1;
                end
            end
            S_RAMP: begin
                if (!bp_stable)                brown = 1'b1;
                else if (flt_hit)              begin trip = 1'b1; trip_rsn = flt_rsn; end
                else if (mod_pg)               begin st_d = S_ON; rty_clr = 1'b1; end
                else if (tmr_q >= pg_timeout)  begin trip = 1'b1; trip_rsn = RSN_INRUSH; end
            end
            S_ON: begin
                if (!bp_stable)   brown = 1'b1;
                else if (flt_hit) begin trip = 1'b1; trip_rsn = flt_rsn; end
                else if (!mod_pg) begin trip = 1'b1; trip_rsn = RSN_UV; end
            end
            S_BACKOFF: begin
                if (tmr_q >= backoff_len && bp_stable) begin
                    st_d            = S_RAMP;
                    ev_d[EV_ENABLE] = 1'b1;
                    ev_d[EV_RETRY]  = 1'b1;
                    tmr_clr         = 1'b1;
                end
            end
            S_HALT:  if (!flt_hit)    st_d = S_IDLE;
            S_LATCH: if (clear_latch) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase

        if (brown) begin
            st_d         = S_IDLE;
            ev_d[EV_DIS] = 1'b1;
            rsn_d        = RSN_BROWN;
        end
        if (trip) begin
            ev_d[EV_DIS]  = 1'b1;
            ev_d[EV_TRIP] = 1'b1;
            rsn_d         = trip_rsn;
            tmr_clr       = 1'b1;
            case (trip_policy)
                2'd0: st_d = S_HALT;
                2'd1: begin
                    if (rty_q >= retry_limit) begin
                        st_d           = S_LATCH;
                        ev_d[EV_LATCH] = 1'b1;
                    end else begin
                        st_d    = S_BACKOFF;
                        rty_inc = 1'b1;
                    end
                end
                default: begin
                    st_d           = S_LATCH;
                    ev_d[EV_LATCH] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 tmr_q <= '0;
        else if (tmr_clr)           tmr_q <= '0;
        else if (tmr_q != TMR_TOP)  tmr_q <= tmr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || rty_clr) rty_q <= '0;
        else if (rty_inc)      rty_q <= rty_q + 1'b1;
    end

    always_comb begin
        slot_en      = (st_q == S_RAMP) || (st_q == S_ON);
        slot_ready   = (st_q == S_ON);
        sync_inhibit = (st_q != S_ON);
        alarm        = (st_q == S_HALT) || (st_q == S_BACKOFF) || (st_q == S_LATCH);
    end

    assign inc_vec[C_INRUSH] = trip && (trip_rsn == RSN_INRUSH);
    assign inc_vec[C_OC]     = trip && (trip_rsn == RSN_OC);
    assign inc_vec[C_UV]     = trip && (trip_rsn == RSN_UV);
    assign inc_vec[C_BROWN]  = brown;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        slot_sat_ctr #(.W(CW)) ctr_i (
            .clk(clk), .rst_n(rst_n), .inc(inc_vec[g]), .cnt(cnt_arr[g])
        );
    end

    assign cnt_inrush   = cnt_arr[C_INRUSH];
    assign cnt_oc       = cnt_arr[C_OC];
    assign cnt_uv       = cnt_arr[C_UV];
    assign cnt_brownout = cnt_arr[C_BROWN];

    slot_evt_log #(.TSW(TSW)) log_i (
        .clk(clk), .rst_n(rst_n), .ev_d(ev_d), .rsn_d(rsn_d),
        .evt_valid(evt_valid), .evt_flags(evt_flags),
        .evt_reason(evt_reason), .evt_time(evt_time)
    );
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk
    import slot_pwr_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bp_stable,
    input logic          mod_pg,
    input logic          clear_latch,
    input logic          slot_en,
    input logic          slot_ready,
    input logic          alarm,
    input logic          evt_valid,
    input logic [4:0]    evt_flags,
    input logic [CW-1:0] cnt_oc,
    input logic [CW-1:0] cnt_brownout,
    input seq_state_t    st_q
);
    a_r1_en_after_bp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_en) |-> $past(bp_stable));

    a_r1_ready_after_pg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_ready) |-> ($past(mod_pg) && $past(slot_en)));

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LATCH && !clear_latch) |=> (st_q == S_LATCH));

    a_r9_oc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_oc >= $past(cnt_oc));

    a_r9_brown_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_brownout >= $past(cnt_brownout));

    a_r10_enable_logged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_en) |-> (evt_valid && evt_flags[EV_ENABLE]));

    a_r10_disable_logged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot_en) |-> (evt_valid && evt_flags[EV_DIS]));

    a_r11_alarm_rail_off: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> !slot_en);
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .bp_stable(bp_stable), .mod_pg(mod_pg),
    .clear_latch(clear_latch), .slot_en(slot_en), .slot_ready(slot_ready),
    .alarm(alarm), .evt_valid(evt_valid), .evt_flags(evt_flags),
    .cnt_oc(cnt_oc), .cnt_brownout(cnt_brownout), .st_q(st_q)
);

// File: tb/slot_pwr_seq_tb.sv
module slot_pwr_seq_tb_top;
    localparam int TW = 12, RW = 4, CW = 8, TSW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bp_stable = 0, mod_pg = 0, flt_uv = 0, flt_ov = 0, flt_oc = 0, flt_ot = 0;
    logic [1:0] trip_policy = 0;
    logic [TW-1:0] pg_timeout = 5, backoff_len = 3;
    logic [RW-1:0] retry_limit = 2;
    logic clear_latch = 0;
    logic slot_en, slot_ready, sync_inhibit, alarm, evt_valid;
    logic [4:0] evt_flags;
    logic [2:0] evt_reason;
    logic [TSW-1:0] evt_time;
    logic [CW-1:0] cnt_inrush, cnt_oc, cnt_uv, cnt_brownout;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    slot_pwr_seq #(.TW(TW), .RW(RW), .CW(CW), .TSW(TSW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic clear_flags();
        flt_uv = 0; flt_ov = 0; flt_oc = 0; flt_ot = 0;
    endtask

    task automatic go_on();
        clear_flags(); bp_stable = 1; mod_pg = 1;
        for (int i = 0; i < 12 && !slot_ready; i++) tick();
        chk(slot_ready, "R1 reach operational", slot_ready, 1);
    endtask

    task automatic trip_check(input string req, input int rsn, input int flags);
        tick();
        chk(!slot_en, {req, " rail dropped"}, slot_en, 0);
        chk(evt_valid && evt_flags == flags, {req, " event flags"}, evt_flags, flags);
        chk(evt_reason == rsn, {req, " reason"}, evt_reason, rsn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int t0, ci, co, cu, cb, e_in, e_oc, e_uv, e_bo, trips, latch_at, c_oc0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // reset state (R11, R9)
        chk(!slot_en && !slot_ready && sync_inhibit && !alarm, "R11 reset outputs", slot_en, 0);
        chk(cnt_inrush == 0 && cnt_oc == 0 && cnt_uv == 0 && cnt_brownout == 0, "R9 reset counters", cnt_oc, 0);
        chk(!evt_valid, "R10 no event at reset", evt_valid, 0);

        // R1: no enable without backplane
        repeat (3) tick();
        chk(!slot_en, "R1 waits for backplane", slot_en, 0);
        bp_stable = 1; tick();
        chk(slot_en && !slot_ready, "R1 enable after backplane", slot_en, 1);
        chk(evt_valid && evt_flags == 5'b00001, "R10 enable event", evt_flags, 1);
        t0 = evt_time;

        // R2: power-good timeout, shutdown policy
        repeat (5) tick();
        chk(slot_en, "R2 still ramping at limit", slot_en, 1);
        trip_check("R2", 5, 5'b00110);
        chk(evt_time - t0 == 6, "R10 timestamp delta", evt_time - t0, 6);
        chk(cnt_inrush == 1, "R2 inrush count", cnt_inrush, 1);
        chk(alarm, "R11 alarm in halt", alarm, 1);
        bp_stable = 0; tick(); tick();
        chk(!alarm && !slot_en, "R4 released to idle", alarm, 0);

        // R1 order and R11 outputs
        mod_pg = 1; bp_stable = 1; tick();
        chk(slot_en && !slot_ready, "R1 not ready on enable", slot_ready, 0);
        tick();
        chk(slot_ready && !sync_inhibit, "R11 ready clears inhibit", sync_inhibit, 0);

        // R3 priority: OC over UV
        flt_oc = 1; flt_uv = 1;
        trip_check("R3 oc>uv", 3, 5'b00110);
        chk(cnt_oc == 1 && cnt_uv == 0, "R3 oc counted not uv", cnt_uv, 0);
        tick();
        chk(alarm && !slot_en, "R4 held while flag high", alarm, 1);
        clear_flags(); tick();
        chk(!alarm && !slot_en, "R4 back to idle", alarm, 0);
        go_on();

        flt_ov = 1; flt_uv = 1; flt_ot = 1;
        trip_check("R3 ov>uv>ot", 2, 5'b00110);
        go_on();
        flt_ot = 1;
        trip_check("R3 ot alone", 4, 5'b00110);
        go_on();
        mod_pg = 0;
        trip_check("R3 pg loss", 1, 5'b00110);
        chk(cnt_uv == 1, "R3 uv count", cnt_uv, 1);
        go_on();

        // R5 retry
        trip_policy = 1; flt_oc = 1;
        trip_check("R5 trip", 3, 5'b00110);
        t0 = evt_time; flt_oc = 0;
        repeat (3) tick();
        chk(!slot_en && alarm, "R5 off during backoff", slot_en, 0);
        tick();
        chk(slot_en && evt_flags == 5'b01001, "R5 retry enable", evt_flags, 9);
        chk(evt_time - t0 == 4, "R5 backoff length", evt_time - t0, 4);
        tick();
        chk(slot_ready, "R5 operational after retry", slot_ready, 1);

        // R6 retry exhaustion
        flt_oc = 1; trips = 0; latch_at = 0;
        for (int i = 0; i < 40 && latch_at == 0; i++) begin
            tick();
            if (evt_valid && evt_flags[2]) begin
                trips++;
                if (evt_flags[4]) latch_at = trips;
            end
        end
        chk(latch_at == 3, "R6 latch on third trip", latch_at, 3);

        // R7 latch hold and clear
        clear_flags();
        repeat (5) tick();
        chk(!slot_en && alarm, "R7 latched stays off", slot_en, 0);
        clear_latch = 1; tick(); clear_latch = 0;
        chk(!alarm && !slot_en, "R7 cleared to idle", alarm, 0);
        tick();
        chk(slot_en, "R7 re-sequences after clear", slot_en, 1);
        tick();
        clear_latch = 1; tick(); tick(); clear_latch = 0;
        chk(slot_ready, "R7 clear ignored when running", slot_ready, 1);
        trip_policy = 2; flt_oc = 1;
        trip_check("R7 latch policy", 3, 5'b10110);
        clear_flags(); clear_latch = 1; tick(); clear_latch = 0;
        go_on();

        // R8 brownout
        cb = cnt_brownout;
        bp_stable = 0; tick();
        chk(!slot_en && !alarm, "R8 brownout disable no alarm", alarm, 0);
        chk(evt_valid && evt_flags == 5'b00010 && evt_reason == 6, "R8 brownout event", evt_flags, 2);
        chk(cnt_brownout == cb + 1, "R8 brownout count", cnt_brownout, cb + 1);

        // random phase: R9/R10/R11 counter tally and invariants
        ci = cnt_inrush; co = cnt_oc; cu = cnt_uv; cb = cnt_brownout;
        e_in = 0; e_oc = 0; e_uv = 0; e_bo = 0;
        pg_timeout = 4; backoff_len = 2;
        for (int i = 0; i < 3000; i++) begin
            trip_policy = 2'($urandom_range(0, 1));
            bp_stable   = ($urandom_range(0, 49) != 0);
            mod_pg      = ($urandom_range(0, 9) != 0);
            flt_uv      = ($urandom_range(0, 39) == 0);
            flt_ov      = ($urandom_range(0, 39) == 0);
            flt_oc      = ($urandom_range(0, 29) == 0);
            flt_ot      = ($urandom_range(0, 39) == 0);
            clear_latch = ($urandom_range(0, 9) == 0);
            tick();
            if (evt_valid && evt_flags[2] && evt_reason == 5) e_in++;
            if (evt_valid && evt_flags[2] && evt_reason == 3) e_oc++;
            if (evt_valid && evt_flags[2] && evt_reason == 1) e_uv++;
            if (evt_valid && !evt_flags[2] && evt_flags[1] && evt_reason == 6) e_bo++;
            if ((slot_ready && !slot_en) || (sync_inhibit == slot_ready) || (alarm && slot_en))
                chk(0, "R11 output invariant", {slot_en, slot_ready, sync_inhibit, alarm}, 0);
        end
        chk(cnt_inrush == sat(ci + e_in), "R9 inrush tally", cnt_inrush, sat(ci + e_in));
        chk(cnt_oc == sat(co + e_oc), "R9 oc tally", cnt_oc, sat(co + e_oc));
        chk(cnt_uv == sat(cu + e_uv), "R9 uv tally", cnt_uv, sat(cu + e_uv));
        chk(cnt_brownout == sat(cb + e_bo), "R9 brownout tally", cnt_brownout, sat(cb + e_bo));

        // R9 saturation
        clear_flags(); clear_latch = 1; tick(); clear_latch = 0;
        trip_policy = 0; pg_timeout = 5; go_on();
        c_oc0 = cnt_oc;
        for (int i = 0; i < 300; i++) begin
            flt_oc = 1;
            for (int k = 0; k < 4 && slot_en; k++) tick();
            flt_oc = 0;
            for (int k = 0; k < 4 && !slot_en; k++) tick();
        end
        chk(cnt_oc == 255, "R9 oc saturates", cnt_oc, 255);
        chk(cnt_oc >= c_oc0, "R9 no wrap", cnt_oc, c_oc0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule